// File: doc/BRIEF.md
# Two-Level Look-Ahead Adder

This block is a purely combinational binary adder that never ripples a carry from one bit or one block to the next. Each operand bit pair yields a generate and a propagate term. Slices of four bits each feed a look-ahead unit. That unit computes every carry inside the slice as a sum of products, working straight from the slice's carry-in. It also condenses the slice into one block-level generate and one block-level propagate.

A second look-ahead unit of the same construction takes the block-level terms and the external carry-in. From them it computes the carry into every slice, and the final carry-out. With the default parameters the adder is 16 bits wide, built from four slices. Setting the width to 32 gives eight slices, and the second level widens to eight inputs with no other change.

The adder is meant for the arithmetic path of a datapath, where the critical delay is the depth of the carry logic.

Top module: `cla_adder`

## Requirements
- R1: For every bit, the generate term is the AND of the two operand bits and the propagate term is their XOR. No bit ever asserts both terms at once.
- R2: The concatenation {carry_out, sum} equals operand_a + operand_b + carry_in, taken modulo 2^(WIDTH+1).
- R3: Inside a 4-bit slice, each carry is a sum of products of that slice's generate terms, propagate terms and slice carry-in, and never a lower carry. Every combination of two nibble operands and a carry-in gives the correct nibble sum, in each slice position.
- R4: A slice's group propagate is asserted exactly when all four of its bits propagate. When it is asserted, the slice's carry-out equals its carry-in.
- R5: The carries into bits 4, 8 and 12 come from the second level. For example, 0x000F + 0x0001 = 0x0010, 0x00FF + 0x0001 = 0x0100, and 0x0FFF + 0x0001 = 0x1000.
- R6: The carry-out is the second level's final carry. 0xFFFF + 0x0001 gives sum 0x0000 with carry-out 1. 0xFFFF + 0xFFFF with carry-in 1 gives sum 0xFFFF with carry-out 1.
- R7: All-zero operands give sum 0 and carry-out 0 when carry-in is 0, and sum 0x0001 when carry-in is 1.
- R8: When every bit propagates, the carry-in reaches the carry-out. 0xAAAA + 0x5555 with carry-in 1 gives sum 0x0000 and carry-out 1; with carry-in 0 it gives 0xFFFF and carry-out 0.
- R9: With WIDTH = 32, the same structure uses eight slices and an eight-input second level, and R2 holds, including for 0xFFFFFFFF + 0x00000001.
- R10: The carry-out that each slice computes internally equals the carry that the second level hands to the next slice, and for the top slice it equals the adder's carry-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_a | input | WIDTH | First addend |
| operand_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
A wrong slice carry shows up at once on the sum bits of that slice. It becomes visible only for operands whose lower bits propagate or generate into the faulty term, which is why every slice position is swept exhaustively. A wrong group generate or group propagate corrupts only the bits above a slice boundary. The boundary-crossing patterns and the all-propagate chains expose it in the same cycle as the stimulus. Because the block has no state, a fault never lingers: each comparison stands on its own inputs.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Width of one first-level look-ahead slice.
  localparam int SLICE_BITS = 4;
  // Default adder width.
  localparam int ADDER_BITS = 16;
endpackage

// File: rtl/pg_cell.sv
module pg_cell #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] prop_o
);
  always_comb begin
    gen_o  = a_i & b_i;
    prop_o = a_i ^ b_i;
  end

  // A bit never both generates and propagates.
  always_comb begin
    p_gen_prop_exclusive_r1: assert ((gen_o & prop_o) == '0)
      else $error("generate and propagate both set");
  end
endmodule

// File: rtl/cla_unit.sv
module cla_unit #(
  parameter int N = 4
) (
  input  logic [N-1:0] prop_i,
  input  logic [N-1:0] gen_i,
  input  logic         cin_i,
  output logic [N-1:0] carry_o,
  output logic         cout_o,
  output logic         grp_prop_o,
  output logic         grp_gen_o
);
  logic [N:0] carry;

  // Every carry is a flat sum of products from cin_i; none uses a lower carry.
  always_comb begin
    logic acc;
    logic prod;
    for (int i = 0; i <= N; i++) begin
      acc = cin_i;
      for (int k = 0; k < i; k++) acc = acc & prop_i[k];
      for (int j = 0; j < i; j++) begin
        prod = gen_i[j];
        for (int k = j + 1; k < i; k++) prod = prod & prop_i[k];
        acc = acc | prod;
      end
      carry[i] = acc;
    end
  end

  always_comb begin
    logic term;
    grp_prop_o = &prop_i;
    grp_gen_o  = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = gen_i[j];
      for (int k = j + 1; k < N; k++) term = term & prop_i[k];
      grp_gen_o = grp_gen_o | term;
    end
  end

  assign carry_o = carry[N-1:0];
  assign cout_o  = carry[N];

  // Local carry relations between neighbouring product terms.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (gen_i[i]) begin
        p_gen_forces_carry_r3: assert (carry[i+1])
          else $error("generate did not force carry");
      end
      if (!gen_i[i] && !prop_i[i]) begin
        p_kill_clears_carry_r3: assert (!carry[i+1])
          else $error("kill did not clear carry");
      end
      if (prop_i[i] && !gen_i[i]) begin
        p_prop_passes_carry_r3: assert (carry[i+1] == carry[i])
          else $error("propagate did not pass carry");
      end
    end
    if (grp_prop_o) begin
      p_group_prop_pass_r4: assert (cout_o == cin_i)
        else $error("group propagate did not pass carry");
    end
  end
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int WIDTH = cla_pkg::ADDER_BITS,
  parameter int SLICE = cla_pkg::SLICE_BITS
) (
  input  logic [WIDTH-1:0] operand_a,
  input  logic [WIDTH-1:0] operand_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  localparam int NBLK = WIDTH / SLICE;

  logic [WIDTH-1:0] bit_gen;
  logic [WIDTH-1:0] bit_prop;
  logic [WIDTH-1:0] bit_carry;
  logic [NBLK-1:0]  blk_gen;
  logic [NBLK-1:0]  blk_prop;
  logic [NBLK-1:0]  blk_cin;
  logic [NBLK-1:0]  blk_cout;
  logic             top_prop;
  logic             top_gen;

  pg_cell #(.W(WIDTH)) u_pg (
    .a_i    (operand_a),
    .b_i    (operand_b),
    .gen_o  (bit_gen),
    .prop_o (bit_prop)
  );

  // First level: one look-ahead unit per slice.
  for (genvar s = 0; s < NBLK; s++) begin : g_slice
    cla_unit #(.N(SLICE)) u_slice (
      .prop_i     (bit_prop[s*SLICE +: SLICE]),
      .gen_i      (bit_gen[s*SLICE +: SLICE]),
      .cin_i      (blk_cin[s]),
      .carry_o    (bit_carry[s*SLICE +: SLICE]),
      .cout_o     (blk_cout[s]),
      .grp_prop_o (blk_prop[s]),
      .grp_gen_o  (blk_gen[s])
    );
  end

  // Second level: block carries from group terms.
  cla_unit #(.N(NBLK)) u_level2 (
    .prop_i     (blk_prop),
    .gen_i      (blk_gen),
    .cin_i      (carry_in),
    .carry_o    (blk_cin),
    .cout_o     (carry_out),
    .grp_prop_o (top_prop),
    .grp_gen_o  (top_gen)
  );

  assign sum = bit_prop ^ bit_carry;

  always_comb begin
    logic [WIDTH:0] ref_total;
    ref_total = {1'b0, operand_a} + {1'b0, operand_b} + {{WIDTH{1'b0}}, carry_in};
    p_sum_matches_r2: assert ({carry_out, sum} == ref_total)
      else $error("sum mismatch");
    for (int s = 0; s + 1 < NBLK; s++) begin
      p_slice_cout_handoff_r10: assert (blk_cout[s] == blk_cin[s+1])
        else $error("slice carry handoff mismatch");
    end
    p_top_slice_cout_r10: assert (blk_cout[NBLK-1] == carry_out)
      else $error("top slice carry mismatch");
    if (top_gen) begin
      p_top_gen_carry_r6: assert (carry_out)
        else $error("group generate without carry-out");
    end
    if (top_prop) begin
      p_full_prop_r8: assert (carry_out == carry_in)
        else $error("full propagate did not pass carry-in");
    end
  end
endmodule

// File: tb/cla_adder_tb.sv
module cla_adder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk;
  logic rst_n;
  logic [15:0] a16, b16, s16;
  logic        ci16, co16;
  logic [31:0] a32, b32, s32;
  logic        ci32, co32;

  int checks;
  int fails;
  bit done;

  cla_adder #(.WIDTH(16), .SLICE(4)) u_dut (
    .operand_a (a16), .operand_b (b16), .carry_in (ci16),
    .sum (s16), .carry_out (co16)
  );

  cla_adder #(.WIDTH(32), .SLICE(4)) u_dut32 (
    .operand_a (a32), .operand_b (b32), .carry_in (ci32),
    .sum (s32), .carry_out (co32)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Drive on the falling edge, compare against the behavioural model 1 ns later.
  task automatic chk16(input logic [15:0] a, input logic [15:0] b, input logic ci,
                       input string req);
    logic [16:0] expv;
    @(negedge clk);
    a16 = a; b16 = b; ci16 = ci;
    #1;
    expv = 17'(a) + 17'(b) + 17'(ci);
    checks++;
    if ({co16, s16} !== expv) begin
      fails++;
      $display("FAIL %s: a=%h b=%h ci=%b actual=%h expected=%h", req, a, b, ci,
               {co16, s16}, expv);
    end
  endtask

  task automatic chk32(input logic [31:0] a, input logic [31:0] b, input logic ci,
                       input string req);
    logic [32:0] expv;
    @(negedge clk);
    a32 = a; b32 = b; ci32 = ci;
    #1;
    expv = 33'(a) + 33'(b) + 33'(ci);
    checks++;
    if ({co32, s32} !== expv) begin
      fails++;
      $display("FAIL %s: a=%h b=%h ci=%b actual=%h expected=%h", req, a, b, ci,
               {co32, s32}, expv);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc >= WATCHDOG_CYCLES) begin
        fails++;
        $display("FAIL watchdog: actual=%0d cycles expected below %0d", cyc, WATCHDOG_CYCLES);
        finish_run();
      end
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0;
    a16 = '0; b16 = '0; ci16 = 1'b0;
    a32 = '0; b32 = '0; ci32 = 1'b0;
    repeat (3) @(posedge clk);
    // Reset state: zero inputs give a zero result (R7).
    @(negedge clk);
    checks++;
    if ({co16, s16} !== 17'h0) begin
      fails++;
      $display("FAIL R7 reset: actual=%h expected=%h", {co16, s16}, 17'h0);
    end
    rst_n = 1'b1;

    // R7 zeros
    chk16(16'h0000, 16'h0000, 1'b0, "R7");
    chk16(16'h0000, 16'h0000, 1'b1, "R7");
    // R3 exhaustive nibble sweep in every slice position (R1, R2 too)
    for (int pos = 0; pos < 4; pos++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          for (int c = 0; c < 2; c++) begin
            chk16(16'(x) << (4*pos), 16'(y) << (4*pos), 1'(c), "R3");
          end
        end
      end
    end
    // R5 block carries into bits 4, 8, 12
    chk16(16'h000F, 16'h0001, 1'b0, "R5");
    chk16(16'h00FF, 16'h0001, 1'b0, "R5");
    chk16(16'h0FFF, 16'h0001, 1'b0, "R5");
    chk16(16'h000F, 16'h0000, 1'b1, "R5");
    chk16(16'h0F0F, 16'h00F1, 1'b0, "R5");
    // R6 carry-out
    chk16(16'hFFFF, 16'h0001, 1'b0, "R6");
    chk16(16'hFFFF, 16'hFFFF, 1'b1, "R6");
    chk16(16'hFFFF, 16'hFFFF, 1'b0, "R6");
    chk16(16'h8000, 16'h8000, 1'b0, "R6");
    // R8 full propagate chain
    chk16(16'hAAAA, 16'h5555, 1'b1, "R8");
    chk16(16'hAAAA, 16'h5555, 1'b0, "R8");
    chk16(16'hFFFF, 16'h0000, 1'b1, "R8");
    // R2 random
    for (int n = 0; n < 3000; n++) begin
      chk16(16'($urandom), 16'($urandom), 1'($urandom), "R2");
    end
    // R9 32-bit instance
    chk32(32'hFFFFFFFF, 32'h00000001, 1'b0, "R9");
    chk32(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, "R9");
    chk32(32'h0000FFFF, 32'h00000001, 1'b0, "R9");
    chk32(32'hAAAAAAAA, 32'h55555555, 1'b1, "R9");
    chk32(32'h00000000, 32'h00000000, 1'b0, "R9");
    for (int n = 0; n < 3000; n++) begin
      chk32($urandom, $urandom, 1'($urandom), "R9");
    end
    finish_run();
  end
endmodule